// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

This block holds a small set of timer channels behind a simple single-cycle register bus. Each channel has a free-running or self-restarting up-counter, a compare register and a control/status word. A slow reference clock is delivered as a one-cycle enable pulse (`slow_tick`). Each channel divides that pulse by a selectable ratio and advances its counter on the result. When the counter meets the compare value, the channel latches a match flag. In periodic mode it also restarts from zero. It can drive its own interrupt line.

Every channel's run control sits in one shared start/stop word, so software starts or stops any mix of channels with a single write. The status flags are cleared by writing zero to them, which lets a read-modify-write that keeps the other bits leave the flags untouched. A new counter value only takes hold after two slow ticks, which mirrors a counter that really lives in the slow domain.

Top module: `cmt_timer`

## Requirements
- R1: After reset the start/stop word reads 0, every control word reads 0, every counter reads 0, every compare register reads 0xFFFFFFFF and all interrupt lines are low.
- R2: Byte address 0x00 is the start/stop word. Channel i's block starts at 0x10 + 0x10·i, with control at +0x0, counter at +0x4 and compare at +0x8. Address bits 1:0 are ignored. Any other address, including +0xC and blocks past the last channel, reads 0 and ignores writes.
- R3: Bit i of the start/stop word runs channel i. Only bits below the channel count are stored. A channel whose bit is 0 keeps its counter frozen.
- R4: Control bits 2:0 pick the count rate from slow ticks. Code 7 counts every tick, 4 counts every 8th, 5 every 32nd and 6 every 128th. Codes 0 to 3 never count.
- R5: Stopping a channel resets its divider phase, so after a restart the first count needs a full divider period.
- R6: A counter write is invisible to reads and to counting until the second slow tick after the write. On that tick the written value replaces the counter.
- R7: With control bit 8 set (periodic), a count step taken while the counter equals the compare value sets the counter to 0, so one period is compare + 1 steps.
- R8: A count step taken while the counter equals the compare value sets the match flag, control bit 15, in both modes. With bit 8 clear the counter carries on to compare + 1.
- R9: A count step from 0xFFFFFFFF that is not a match wraps the counter to 0 and sets the overflow flag, control bit 14.
- R10: A control write clears bit 15 or bit 14 when the written bit is 0 and leaves it unchanged when the written bit is 1. Bits 8, 7, 5:4 and 2:0 read back as written, and all other bits read 0.
- R11: `irq[i]` is high exactly while channel i's match flag is set, its bit 7 is 1 and its bits 5:4 equal 2.
- R12: The compare register accepts and reads back any 32-bit value, independently per channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| slow_tick | input | 1 | One-cycle pulse per slow reference clock period |
| irq | output | NUM_CH (2) | Per-channel interrupt request |

## Verification
The bench builds the block with its defaults: two channels, 32-bit counters and an 8-bit address. This keeps one channel idle as a witness while the other is exercised. It sweeps periodic mode for every compare value from 0 to 5 over three full periods, so each restart point and every flag-set cycle is checked against `n mod (compare+1)`. It also runs every clock-select code for just over three divider periods, up to the 128 divider. With 32-bit counters, overflow is reached by loading a value just below the top through the delayed counter write.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int WORD_W = 32;
    localparam int PRE_W  = 7;

    localparam logic [1:0] REQ_IRQ = 2'd2;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CMP   = 2'd2,
        REG_NONE  = 2'd3
    } chreg_e;

    typedef struct packed {
        logic       match;
        logic       ovf;
        logic       periodic;
        logic       irq_en;
        logic [1:0] req;
        logic [2:0] clk_sel;
    } ctrl_t;

    // slow ticks per count step; 0 means the code never counts
    function automatic logic [7:0] div_of(input logic [2:0] sel);
        case (sel)
            3'd4:    div_of = 8'd8;
            3'd5:    div_of = 8'd32;
            3'd6:    div_of = 8'd128;
            3'd7:    div_of = 8'd1;
            default: div_of = 8'd0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_word(input ctrl_t c);
        ctrl_word = {16'b0, c.match, c.ovf, 5'b0, c.periodic, c.irq_en,
                     1'b0, c.req, 1'b0, c.clk_sel};
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       step
);
    logic [7:0]       div;
    logic [PRE_W-1:0] phase_q;
    logic             at_end;

    assign div    = div_of(sel);
    assign at_end = (phase_q == PRE_W'(div - 8'd1));
    assign step   = run && tick && (div != 8'd0) && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
        end else if (tick && div != 8'd0) begin
            phase_q <= at_end ? '0 : phase_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic              wr_ctrl,
    input  logic              wr_count,
    input  logic              wr_cmp,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cmp,
    output logic              step_o,
    output logic              load_o,
    output logic              irq
);
    logic             pre_step;
    logic [CNT_W-1:0] pend_val;
    logic [1:0]       pend_cnt;
    logic             hit;
    logic             wrap;
    logic             unused_ctrl;

    assign unused_ctrl = ^{wdata[13:9], wdata[6], wdata[3]};

    cmt_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .run  (run),
        .sel  (ctrl.clk_sel),
        .step (pre_step)
    );

    assign load_o = tick && (pend_cnt == 2'd1) && !wr_count;
    assign step_o = pre_step && !load_o;
    assign hit    = (count == cmp);
    assign wrap   = (count == '1) && !hit;
    assign irq    = ctrl.match && ctrl.irq_en && (ctrl.req == REQ_IRQ);

    // delayed counter load
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_val <= '0;
            pend_cnt <= 2'd0;
        end else if (wr_count) begin
            pend_val <= wdata[CNT_W-1:0];
            pend_cnt <= 2'd2;
        end else if (tick && pend_cnt != 2'd0) begin
            pend_cnt <= pend_cnt - 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_o) begin
            count <= pend_val;
        end else if (step_o) begin
            count <= (ctrl.periodic && hit) ? '0 : count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= '1;
        end else if (wr_cmp) begin
            cmp <= wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.match    <= ctrl.match & wdata[15];
                ctrl.ovf      <= ctrl.ovf & wdata[14];
                ctrl.periodic <= wdata[8];
                ctrl.irq_en   <= wdata[7];
                ctrl.req      <= wdata[5:4];
                ctrl.clk_sel  <= wdata[2:0];
            end
            if (step_o && hit) ctrl.match <= 1'b1;
            if (step_o && wrap) ctrl.ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              slow_tick,
    output logic [NUM_CH-1:0] irq
);
    localparam int BLK_W = ADDR_W - 4;

    logic [NUM_CH-1:0] run_q;
    ctrl_t             ch_ctrl  [NUM_CH];
    logic [CNT_W-1:0]  ch_count [NUM_CH];
    logic [CNT_W-1:0]  ch_cmp   [NUM_CH];
    logic [NUM_CH-1:0] ch_step;
    logic [NUM_CH-1:0] ch_load;
    logic              start_sel;
    chreg_e            reg_sel;
    logic              unused_low;

    assign unused_low = ^bus_addr[1:0];
    assign start_sel  = (bus_addr[ADDR_W-1:2] == '0);
    assign reg_sel    = chreg_e'(bus_addr[3:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (bus_wr && start_sel) begin
            run_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic blk_hit;
        assign blk_hit = (bus_addr[ADDR_W-1:4] == BLK_W'(i + 1));

        cmt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (slow_tick),
            .run      (run_q[i]),
            .wr_ctrl  (bus_wr && blk_hit && reg_sel == REG_CTRL),
            .wr_count (bus_wr && blk_hit && reg_sel == REG_COUNT),
            .wr_cmp   (bus_wr && blk_hit && reg_sel == REG_CMP),
            .wdata    (bus_wdata),
            .ctrl     (ch_ctrl[i]),
            .count    (ch_count[i]),
            .cmp      (ch_cmp[i]),
            .step_o   (ch_step[i]),
            .load_o   (ch_load[i]),
            .irq      (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (start_sel) begin
            bus_rdata = 32'(run_q);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr[ADDR_W-1:4] == BLK_W'(c + 1)) begin
                case (reg_sel)
                    REG_CTRL:  bus_rdata = ctrl_word(ch_ctrl[c]);
                    REG_COUNT: bus_rdata = 32'(ch_count[c]);
                    REG_CMP:   bus_rdata = 32'(ch_cmp[c]);
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmt_timer_checks.sv
module cmt_timer_checks
    import cmt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_CH-1:0] run_q,
    input ctrl_t             ch_ctrl  [NUM_CH],
    input logic [CNT_W-1:0]  ch_count [NUM_CH],
    input logic [CNT_W-1:0]  ch_cmp   [NUM_CH],
    input logic [NUM_CH-1:0] ch_step,
    input logic [NUM_CH-1:0] ch_load
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic ctrl_wr;
        assign ctrl_wr = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(4 * (i + 1)));

        // R3: a stopped channel with no load pending keeps its count
        a_r3_stopped_frozen: assert property (@(posedge clk) disable iff (rst)
            (!run_q[i] && !ch_load[i]) |=> $stable(ch_count[i]));

        // R7: periodic restart after a match step
        a_r7_periodic_restart: assert property (@(posedge clk) disable iff (rst)
            (ch_step[i] && !ch_load[i] && ch_ctrl[i].periodic && ch_count[i] == ch_cmp[i])
            |=> (ch_count[i] == '0));

        // R8: the match flag only rises from an equal count
        a_r8_match_origin: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_ctrl[i].match) |-> $past(ch_count[i] == ch_cmp[i]));

        // R9: the overflow flag only rises from the top count
        a_r9_ovf_origin: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_ctrl[i].ovf) |-> $past(ch_count[i] == '1));

        // R10: writing 0 to the match flag clears it unless a match step lands
        a_r10_flag_clear: assert property (@(posedge clk) disable iff (rst)
            (ctrl_wr && !bus_wdata[15] && !ch_step[i]) |=> !ch_ctrl[i].match);
    end
endmodule

bind cmt_timer cmt_timer_checks #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_checks (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run_q     (run_q),
    .ch_ctrl   (ch_ctrl),
    .ch_count  (ch_count),
    .ch_cmp    (ch_cmp),
    .ch_step   (ch_step),
    .ch_load   (ch_load)
);

// File: tb/cmt_timer_bench.sv
`timescale 1ns/1ps
module cmt_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        slow_tick = 1'b0;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cmt_timer u_cmt_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .slow_tick (slow_tick),
        .irq       (irq)
    );

    function automatic logic [7:0] base(input int c);
        return 8'(16 + 16 * c);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic load(input int c, input logic [31:0] v);
        wr(base(c) + 8'h4, v);
        tick(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        logic [31:0] c1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, d); check("R1 start", d, 0);
        for (int c = 0; c < 2; c++) begin
            rd(base(c), d);        check("R1 ctrl", d, 0);
            rd(base(c) + 8'h4, d); check("R1 count", d, 0);
            rd(base(c) + 8'h8, d); check("R1 cmp", d, 32'hFFFF_FFFF);
        end
        check("R1 irq", 32'(irq), 0);

        // R12 / R2 compare read-back and map
        wr(base(1) + 8'h8, 32'h1234_5678);
        wr(base(0) + 8'h8, 32'hA5A5_0F0F);
        rd(base(1) + 8'h8, d); check("R12 cmp ch1", d, 32'h1234_5678);
        rd(base(0) + 8'h9, d); check("R2 low bits ignored", d, 32'hA5A5_0F0F);
        wr(base(0) + 8'hC, 32'hFFFF_FFFF);
        rd(base(0) + 8'hC, d); check("R2 hole", d, 0);
        rd(8'h30, d);          check("R2 absent ch", d, 0);
        rd(8'h0C, d);          check("R2 unmapped", d, 0);

        // R6 delayed counter write (stopped)
        rd(base(0) + 8'h4, v);
        wr(base(0) + 8'h4, 32'd100);
        rd(base(0) + 8'h4, d); check("R6 before tick", d, v);
        tick(1);
        rd(base(0) + 8'h4, d); check("R6 after 1 tick", d, v);
        tick(1);
        rd(base(0) + 8'h4, d); check("R6 after 2 ticks", d, 100);

        // R7 / R8 periodic sweep on ch0, ch1 idle
        rd(base(1) + 8'h4, c1);
        for (int K = 0; K <= 5; K++) begin
            wr(8'h00, 0);
            wr(base(0) + 8'h8, K);
            wr(base(0), 32'h0107);
            load(0, 0);
            wr(8'h00, 1);
            for (int n = 1; n <= 3 * (K + 1); n++) begin
                tick(1);
                rd(base(0) + 8'h4, d); check("R7 periodic count", d, n % (K + 1));
                rd(base(0), d);        check("R8 match flag", 32'(d[15]), 32'(n >= K + 1));
            end
        end
        rd(base(1) + 8'h4, d); check("R3 idle ch frozen", d, c1);

        // R4 clock-select sweep
        for (int s = 0; s < 8; s++) begin
            int dv;
            int t;
            dv = (s == 4) ? 8 : (s == 5) ? 32 : (s == 6) ? 128 : (s == 7) ? 1 : 0;
            t  = (dv == 0) ? 20 : 3 * dv + 1;
            wr(8'h00, 0);
            wr(base(0) + 8'h8, 32'hFFFF_FFFF);
            wr(base(0), 32'(s));
            load(0, 0);
            wr(8'h00, 1);
            tick(t);
            rd(base(0) + 8'h4, d);
            check("R4 rate", d, (dv == 0) ? 0 : t / dv);
        end

        // R5 divider phase reset on stop
        wr(8'h00, 0);
        wr(base(0), 32'h0004);
        load(0, 0);
        wr(8'h00, 1); tick(5);
        wr(8'h00, 0); wr(8'h00, 1); tick(5);
        rd(base(0) + 8'h4, d); check("R5 phase reset", d, 0);
        tick(3);
        rd(base(0) + 8'h4, d); check("R5 full period", d, 1);

        // R8 non-periodic continues past match
        wr(8'h00, 0);
        wr(base(0), 32'h0007);
        wr(base(0) + 8'h8, 3);
        load(0, 0);
        wr(8'h00, 1); tick(10);
        rd(base(0) + 8'h4, d); check("R8 runs past", d, 10);
        rd(base(0), d);        check("R8 flags", d & 32'hC000, 32'h8000);

        // R9 overflow
        wr(8'h00, 0);
        wr(base(0), 32'h0007);
        wr(base(0) + 8'h8, 5);
        load(0, 32'hFFFF_FFFE);
        wr(8'h00, 1); tick(2);
        rd(base(0) + 8'h4, d); check("R9 wrapped", d, 0);
        rd(base(0), d);        check("R9 ovf only", d & 32'hC000, 32'h4000);
        tick(6);
        wr(8'h00, 0);
        rd(base(0), d);        check("R8 both flags", d & 32'hC000, 32'hC000);

        // R10 write-zero clear and field read-back
        wr(base(0), 32'hFFFF_41B7);
        rd(base(0), d);        check("R10 keep ovf clear match", d, 32'h41B7);
        wr(base(0), 32'h0000_0007);
        rd(base(0), d);        check("R10 clear ovf", d, 32'h0007);

        // R11 interrupt gating
        rd(base(0) + 8'h4, v);
        wr(base(0) + 8'h8, v);
        wr(8'h00, 1); tick(1); wr(8'h00, 0);
        wr(base(0), 32'h80A7); check("R11 irq on", 32'(irq), 32'h1);
        wr(base(0), 32'h8097); check("R11 req dma", 32'(irq), 0);
        wr(base(0), 32'h8027); check("R11 ie off", 32'(irq), 0);
        wr(base(0), 32'h80A7); check("R11 irq again", 32'(irq), 32'h1);
        wr(base(0), 32'h00A7); check("R11 cleared", 32'(irq), 0);

        // R3 per-bit start
        wr(base(1), 32'h0007);
        rd(base(0) + 8'h4, v);
        rd(base(1) + 8'h4, c1);
        wr(8'h00, 32'h2);
        rd(8'h00, d);          check("R3 start readback", d, 2);
        tick(3);
        rd(base(1) + 8'h4, d); check("R3 ch1 runs", d, c1 + 3);
        rd(base(0) + 8'h4, d); check("R3 ch0 frozen", d, v);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d);          check("R3 width", d, 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule